// File: doc/BRIEF.md
# Data Cache Line State Controller

This block governs the coherence state of one data cache line. It also orders the bus traffic and local array writes that a processor load or store needs. Each access arrives as a one-cycle `acc_valid` pulse carrying these inputs:

- direction and byte enables;
- a hit indication;
- the cacheability request and the cache-enable response;
- the page write-through attribute and the bus write-back select;
- a write-allocate qualifier.

Tag lookup happens outside the block, and the block has no snoop input.

All access inputs are sampled once, in the cycle the access is accepted. The decision between write-back and write-through is made from that sample. A line is held write-back only when the page attribute is low and the bus select is high. The controller can run a single bus read, a single bus write, or a burst line fill made of beats. It can also run a merge of the stored bytes into the array. It runs these in a fixed order and keeps `busy` high throughout. The new line state is committed in one final cycle.

Bus transfers use a request/acknowledge pair. `bus_req` and `bus_op` stay steady until `bus_ack` is seen. A single transfer ends on its first acknowledge. A burst ends after one acknowledge per beat.

Top module: `line_state_ctrl`

## Requirements
- R1: A synchronous reset sets the line state to Invalid (code 0), drops `busy` and drops `bus_req`. This holds even in the middle of a burst.
- R2: A read miss that is not cacheable runs exactly one single read (`bus_op` 0) carrying the access byte enables, and leaves the line Invalid. An access is not cacheable when `cache_req` or `cache_en` is low.
- R3: A read miss with `cache_req` and `cache_en` both high runs a burst fill (`bus_op` 2). The burst has LINE_BYTES/BE_W beats, all byte enables are set, `fill_we` pulses on every beat, and `fill_beat` counts 0 upward. The line ends Exclusive (code 2) if `page_wt` is low and `wb_sel` is high, and Shared (code 1) otherwise.
- R4: A read hit on a Shared, Exclusive or Modified line causes no bus request and no array write, and leaves the state unchanged.
- R5: A write miss with `wr_alloc` low runs exactly one single write (`bus_op` 1) carrying the access byte enables, and leaves the line Invalid.
- R6: A write miss with `wr_alloc` high in write-back mode runs a burst fill, then one array merge (`arr_we`, with `arr_be` equal to the access byte enables) after the last beat. It runs no single write, and the line ends Modified (code 3).
- R7: A write miss with `wr_alloc` high in write-through mode runs a burst fill, then an array merge, then one single write, in that order. The line ends Shared.
- R8: A write hit on an Exclusive or Modified line runs one array merge and no bus transfer, and the line ends Modified.
- R9: A write hit on a Shared line runs an array merge followed by one single write. The line ends Exclusive in write-back mode and Shared otherwise.
- R10: `busy` stays high from the cycle after acceptance until the commit cycle. The line state changes only at commit. Any access inputs presented while busy are ignored.
- R11: A hit indication on an Invalid line is handled as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access presented; accepted when not busy |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_be | input | BE_W | Access byte enables |
| acc_hit | input | 1 | Tag match from outside lookup |
| cache_req | input | 1 | Processor asks for the access to be cacheable |
| cache_en | input | 1 | Bus response allowing a line fill |
| page_wt | input | 1 | Page write-through attribute |
| wb_sel | input | 1 | Bus write-back select (1 = write-back) |
| wr_alloc | input | 1 | Write-allocate conditions met |
| busy | output | 1 | Access sequence in progress |
| line_state | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified |
| bus_req | output | 1 | Bus transfer request |
| bus_op | output | 2 | 0 single read, 1 single write, 2 burst fill |
| bus_be | output | BE_W | Byte enables of the transfer |
| bus_ack | input | 1 | Transfer (or beat) completes at this edge |
| fill_we | output | 1 | Write fill beat into the array |
| fill_beat | output | log2(beats) | Index of the fill beat |
| arr_we | output | 1 | Merge store bytes into the array |
| arr_be | output | BE_W | Byte enables of the merge |

## Verification
The bench builds the block with its default parameters: 8-byte beats and a 32-byte line, which gives a four-beat fill and a two-bit beat index. With this setting the bench can count every beat and confirm that the beat index wraps correctly. It can also check that the merge waits for the fourth acknowledge and that the trailing write-through store comes after the merge. A reset applied in the middle of the four-beat burst is covered as well. The bench also presents conflicting inputs throughout a busy sequence to show that only the sample taken at acceptance counts.

// File: rtl/line_state_ctrl.sv
module line_state_ctrl #(
  parameter int BE_W       = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [BE_W-1:0]      acc_be,
  input  logic                 acc_hit,
  input  logic                 cache_req,
  input  logic                 cache_en,
  input  logic                 page_wt,
  input  logic                 wb_sel,
  input  logic                 wr_alloc,
  output logic                 busy,
  output logic [1:0]           line_state,
  output logic                 bus_req,
  output logic [1:0]           bus_op,
  output logic [BE_W-1:0]      bus_be,
  input  logic                 bus_ack,
  output logic                 fill_we,
  output logic [((LINE_BYTES/BE_W) > 1 ? $clog2(LINE_BYTES/BE_W) : 1)-1:0] fill_beat,
  output logic                 arr_we,
  output logic [BE_W-1:0]      arr_be
);
  localparam int BEATS = LINE_BYTES / BE_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] OP_SRD = 2'd0, OP_SWR = 2'd1, OP_BRD = 2'd2;

  typedef enum logic [2:0] {P_IDLE, P_SRD, P_SWR, P_FILL, P_MERGE, P_COMMIT} phase_t;

  phase_t           phase;
  logic [1:0]       tgt;
  logic [BE_W-1:0]  be_q;
  logic             wr_q;
  logic             wt_after;
  logic [CNT_W-1:0] beat;

  wire wb_mode = ~page_wt & wb_sel;
  wire miss    = ~acc_hit | (line_state == ST_I);
  wire accept  = acc_valid & (phase == P_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= P_IDLE;
      line_state <= ST_I;
      tgt        <= ST_I;
      be_q       <= '0;
      wr_q       <= 1'b0;
      wt_after   <= 1'b0;
      beat       <= '0;
    end else begin
      case (phase)
        P_IDLE: if (acc_valid) begin
          be_q     <= acc_be;
          wr_q     <= acc_write;
          beat     <= '0;
          wt_after <= 1'b0;
          if (!acc_write) begin
            if (!miss) begin
              phase <= P_COMMIT;
              tgt   <= line_state;
            end else if (cache_req && cache_en) begin
              phase <= P_FILL;
              tgt   <= wb_mode ? ST_E : ST_S;
            end else begin
              phase <= P_SRD;
              tgt   <= ST_I;
            end
          end else begin
            if (!miss) begin
              phase <= P_MERGE;
              if (line_state == ST_S) begin
                wt_after <= 1'b1;
                tgt      <= wb_mode ? ST_E : ST_S;
              end else begin
                tgt <= ST_M;
              end
            end else if (wr_alloc) begin
              phase    <= P_FILL;
              wt_after <= ~wb_mode;
              tgt      <= wb_mode ? ST_M : ST_S;
            end else begin
              phase <= P_SWR;
              tgt   <= ST_I;
            end
          end
        end
        P_SRD, P_SWR: if (bus_ack) phase <= P_COMMIT;
        P_FILL: if (bus_ack) begin
          beat <= beat + 1'b1;
          if (beat == LAST) phase <= wr_q ? P_MERGE : P_COMMIT;
        end
        P_MERGE: phase <= wt_after ? P_SWR : P_COMMIT;
        P_COMMIT: begin
          line_state <= tgt;
          phase      <= P_IDLE;
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  assign busy      = (phase != P_IDLE);
  assign bus_req   = (phase == P_SRD) | (phase == P_SWR) | (phase == P_FILL);
  assign bus_op    = (phase == P_FILL) ? OP_BRD : (phase == P_SWR) ? OP_SWR : OP_SRD;
  assign bus_be    = (phase == P_FILL) ? {BE_W{1'b1}} : be_q;
  assign fill_we   = (phase == P_FILL) & bus_ack;
  assign fill_beat = beat;
  assign arr_we    = (phase == P_MERGE);
  assign arr_be    = be_q;

  assert_rst_R1: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (line_state == ST_I && !bus_req && !busy));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && line_state != $past(line_state)) |-> $past(phase) == P_COMMIT);

  assert_readhit_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && !acc_write && !miss) |=> (!bus_req && !arr_we));

  assert_merge_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !bus_req);

  assert_merge_after_fill_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == P_FILL && phase == P_MERGE) |-> $past(bus_ack));

  assert_mod_from_store_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && line_state == ST_M && $past(line_state) != ST_M) |-> $past(wr_q));
endmodule

// File: tb/tb_line_state_ctrl.sv
module tb_line_state_ctrl;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst = 1, acc_valid = 0, acc_write = 0, acc_hit = 0, cache_req = 0, cache_en = 0;
  logic page_wt = 0, wb_sel = 0, wr_alloc = 0, bus_ack = 0;
  logic [7:0] acc_be = 0;
  logic busy, bus_req, fill_we, arr_we;
  logic [1:0] line_state, bus_op, fill_beat;
  logic [7:0] bus_be, arr_be;

  line_state_ctrl dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write), .acc_be(acc_be),
    .acc_hit(acc_hit), .cache_req(cache_req), .cache_en(cache_en), .page_wt(page_wt),
    .wb_sel(wb_sel), .wr_alloc(wr_alloc), .busy(busy), .line_state(line_state),
    .bus_req(bus_req), .bus_op(bus_op), .bus_be(bus_be), .bus_ack(bus_ack),
    .fill_we(fill_we), .fill_beat(fill_beat), .arr_we(arr_we), .arr_be(arr_be));

  int compared = 0, mismatched = 0;
  int n_srd, n_swr, n_beats, n_mrg, beats_at_m, swr_at_m;
  bit held_ok, be_ok, order_ok;

  typedef struct packed {
    logic [3:0] rq;
    logic [1:0] pre;
    logic wr, hit, creq, cen, pwt, wbs, wal;
    logic [1:0] e_srd, e_swr;
    logic [2:0] e_beats;
    logic [1:0] e_mrg, e_st;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd2,  2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd1,2'd0,3'd0,2'd0,2'd0}, // R2
    '{4'd2,  2'd0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 2'd1,2'd0,3'd0,2'd0,2'd0}, // R2
    '{4'd3,  2'd0, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,2'd0,3'd4,2'd0,2'd2}, // R3
    '{4'd3,  2'd0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0, 2'd0,2'd0,3'd4,2'd0,2'd1}, // R3
    '{4'd3,  2'd0, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0,3'd4,2'd0,2'd1}, // R3
    '{4'd4,  2'd1, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,2'd0,3'd0,2'd0,2'd1}, // R4
    '{4'd4,  2'd2, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0,2'd0,3'd0,2'd0,2'd2}, // R4
    '{4'd4,  2'd3, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 2'd0,2'd0,3'd0,2'd0,2'd3}, // R4
    '{4'd5,  2'd0, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,2'd1,3'd0,2'd0,2'd0}, // R5
    '{4'd6,  2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0,3'd4,2'd1,2'd3}, // R6
    '{4'd7,  2'd0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 2'd0,2'd1,3'd4,2'd1,2'd1}, // R7
    '{4'd8,  2'd2, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0,2'd0,3'd0,2'd1,2'd3}, // R8
    '{4'd8,  2'd3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0,3'd0,2'd1,2'd3}, // R8
    '{4'd9,  2'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0,2'd1,3'd0,2'd1,2'd2}, // R9
    '{4'd9,  2'd1, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 2'd0,2'd1,3'd0,2'd1,2'd1}, // R9
    '{4'd9,  2'd1, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd1,3'd0,2'd1,2'd1}, // R9
    '{4'd11, 2'd0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,2'd0,3'd4,2'd0,2'd2}, // R11
    '{4'd11, 2'd0, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,2'd1,3'd0,2'd0,2'd0}  // R11
  };

  task automatic check(input string what, input int rq, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; acc_valid = 0; bus_ack = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic access(input logic wr, hit, creq, cen, pwt, wbs, wal, input bit interfere);
    logic [1:0] pre;
    int cyc;
    n_srd = 0; n_swr = 0; n_beats = 0; n_mrg = 0; beats_at_m = -1; swr_at_m = -1;
    held_ok = 1; be_ok = 1; order_ok = 1; cyc = 0;
    @(negedge clk);
    pre = line_state;
    acc_write = wr; acc_hit = hit; cache_req = creq; cache_en = cen;
    page_wt = pwt; wb_sel = wbs; wr_alloc = wal; acc_be = 8'h3C; acc_valid = 1;
    @(posedge clk); @(negedge clk);
    if (interfere) begin
      acc_write = ~wr; acc_hit = ~hit; cache_req = ~creq; cache_en = ~cen;
      page_wt = ~pwt; wb_sel = ~wbs; wr_alloc = ~wal; acc_be = 8'hC1;
    end else acc_valid = 0;
    while (busy && cyc < 100) begin
      if (line_state != pre) held_ok = 0;
      if (arr_we) begin
        n_mrg++; beats_at_m = n_beats; swr_at_m = n_swr;
        if (arr_be != 8'h3C) be_ok = 0;
      end
      bus_ack = bus_req;
      #1;
      if (bus_req) begin
        case (bus_op)
          2'd0: begin n_srd++; if (bus_be != 8'h3C) be_ok = 0; end
          2'd1: begin n_swr++; if (bus_be != 8'h3C) be_ok = 0; end
          2'd2: begin
            if (fill_beat != 2'(n_beats) || !fill_we) order_ok = 0;
            if (bus_be != 8'hFF) be_ok = 0;
            n_beats++;
          end
          default: order_ok = 0;
        endcase
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    bus_ack = 0; acc_valid = 0;
  endtask

  task automatic prep(input logic [1:0] st);
    do_reset();
    if (st == 2'd1) access(0, 0, 1, 1, 1, 0, 0, 0);
    if (st >= 2'd2) access(0, 0, 1, 1, 0, 1, 0, 0);
    if (st == 2'd3) access(1, 1, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic check_row(input vec_t v, input string tag);
    int rq;
    rq = int'(v.rq);
    check({tag, " single reads"}, rq, n_srd, int'(v.e_srd));
    check({tag, " single writes"}, rq, n_swr, int'(v.e_swr));
    check({tag, " fill beats"}, rq, n_beats, int'(v.e_beats));
    check({tag, " merges"}, rq, n_mrg, int'(v.e_mrg));
    check({tag, " final state"}, rq, int'(line_state), int'(v.e_st));
    check({tag, " state held while busy"}, 10, int'(held_ok), 1);
    check({tag, " byte enables"}, rq, int'(be_ok), 1);
    check({tag, " beat order"}, rq, int'(order_ok), 1);
    if (v.e_mrg != 0) begin
      check({tag, " beats before merge"}, rq, beats_at_m, int'(v.e_beats));
      check({tag, " writes before merge"}, rq, swr_at_m, 0);
    end
  endtask

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset();
    // R1: state after reset
    check("reset state", 1, int'(line_state), 0);
    check("reset busy", 1, int'(busy), 0);
    check("reset bus_req", 1, int'(bus_req), 0);

    for (int i = 0; i < NV; i++) begin
      prep(VEC[i].pre);
      access(VEC[i].wr, VEC[i].hit, VEC[i].creq, VEC[i].cen, VEC[i].pwt, VEC[i].wbs, VEC[i].wal, 0);
      check_row(VEC[i], $sformatf("row%0d", i));
    end

    // R10: conflicting inputs held during busy are ignored
    prep(2'd0);
    access(0, 0, 1, 1, 0, 1, 0, 1);
    check_row(VEC[2], "R10 busy-ignore fill");
    prep(2'd1);
    access(1, 1, 0, 0, 0, 1, 0, 1);
    check_row(VEC[13], "R10 busy-ignore store");
    check("R10 idle after sequence", 10, int'(busy), 0);

    // R1: reset in the middle of a burst fill
    prep(2'd2);
    @(negedge clk);
    acc_write = 1; acc_hit = 0; wr_alloc = 1; page_wt = 0; wb_sel = 1; acc_valid = 1;
    @(posedge clk); @(negedge clk);
    acc_valid = 0; bus_ack = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("busy mid-burst", 10, int'(busy), 1);
    rst = 1; bus_ack = 0;
    @(posedge clk); @(negedge clk);
    check("mid-burst reset state", 1, int'(line_state), 0);
    check("mid-burst reset bus_req", 1, int'(bus_req), 0);
    check("mid-burst reset busy", 1, int'(busy), 0);
    rst = 0;
    @(negedge clk);
    check("no merge after reset", 1, int'(arr_we), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule